// File: doc/BRIEF.md
# PHY Control Register Mode Controller

This block holds the 16-bit mode word of an Ethernet PHY port, reached through a management register interface. The interface has an address, write data, a write strobe and combinational read data. The fields of the word set how the port behaves: manual speed and duplex, or link settings taken from an external auto-negotiation engine. The word also selects digital loopback of the transmit nibble stream into the receive path, isolation of the MII data path, power-down, and a collision-test mode.

A write with the top bit set starts a soft reset. The word returns to its defaults and the data path is held idle for a fixed number of cycles. The bit then clears itself. A short guard window follows, during which the management side must not accept a new start of frame. A wake timer holds `port_ready` low while the port is powered down, isolated or in reset, and for a parameterised delay after those conditions clear. Isolation appears as an output-enable signal, not as real tri-state pads.

Top module: `phy_mode_ctl`

## Requirements
- R1: After reset the word at address 0 reads 0x1100 with bit 13 equal to `strap_speed`. At that point `port_ready`, `st_guard` and `an_restart` are low.
- R2: A write to address 0 without bit 15 stores bits 14 (loopback), 13 (speed), 12 (auto-negotiation enable), 11 (power-down), 10 (isolate), 8 (duplex) and 7 (collision test). Bits 9 and 6..0 always read 0, so the read value is the written value ANDed with 0x7D80.
- R3: Reads from any address other than 0 return 0, and writes to those addresses leave the word unchanged.
- R4: Writing bit 15 loads the defaults at once. Bit 15 then reads 1 for exactly RST_CYCLES cycles before it clears itself. Writes made while it reads 1 are ignored.
- R5: `st_guard` is high for exactly 3 cycles starting on the cycle in which the reset bit clears.
- R6: With bit 12 at 0, `link_100` equals bit 13 and `link_fdx` equals bit 8. With bit 12 at 1, they follow `an_res_100` and `an_res_fdx`, whatever bits 13 and 8 hold.
- R7: Writing bit 9 as 1 gives a one-cycle `an_restart` pulse in the cycle after the write.
- R8: In loopback, `rx_d`/`rx_dv`/`rx_er` repeat `tx_d`/`tx_en`/`tx_er` exactly LOOP_DEPTH cycles later and in order. In that mode `crs` equals `rx_dv`, the line transmit outputs stay 0, and `col` stays 0 unless collision test is set.
- R9: With isolate set, `mii_oe` is 0 and the transmit inputs have no effect: the line transmit outputs and the receive outputs are 0. The word stays readable and writable.
- R10: With power-down set, all line transmit outputs, receive outputs, `col` and `crs` are 0, and the word keeps its contents.
- R11: `port_ready` is 0 while power-down, isolate or soft reset is active. It rises exactly WAKE_CYCLES cycles after the write that clears the last of them.
- R12: In normal operation the line transmit outputs equal the transmit inputs and the receive outputs equal the line receive inputs. `col` equals `tx_en` when collision test is set and `line_col` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_speed | input | 1 | Reset value of the speed bit |
| mg_addr | input | 5 | Management register address |
| mg_wdata | input | 16 | Management write data |
| mg_we | input | 1 | Management write strobe |
| mg_rdata | output | 16 | Management read data (combinational) |
| an_res_100 | input | 1 | Speed resolved by auto-negotiation |
| an_res_fdx | input | 1 | Duplex resolved by auto-negotiation |
| link_100 | output | 1 | Effective speed, 1 = 100 Mbps |
| link_fdx | output | 1 | Effective duplex, 1 = full |
| an_restart | output | 1 | One-cycle auto-negotiation restart pulse |
| st_guard | output | 1 | Start-of-frame blocking window after soft reset |
| port_ready | output | 1 | Port operational |
| mii_oe | output | 1 | Output enable of MII outputs, 0 when isolated |
| tx_d | input | DW | Transmit data from MAC |
| tx_en | input | 1 | Transmit enable from MAC |
| tx_er | input | 1 | Transmit error from MAC |
| rx_d | output | DW | Receive data to MAC |
| rx_dv | output | 1 | Receive data valid to MAC |
| rx_er | output | 1 | Receive error to MAC |
| col | output | 1 | Collision to MAC |
| crs | output | 1 | Carrier sense to MAC |
| line_tx_d | output | DW | Transmit data toward the medium |
| line_tx_en | output | 1 | Transmit enable toward the medium |
| line_tx_er | output | 1 | Transmit error toward the medium |
| line_rx_d | input | DW | Receive data from the medium |
| line_rx_dv | input | 1 | Receive valid from the medium |
| line_rx_er | input | 1 | Receive error from the medium |
| line_col | input | 1 | Collision from the medium |
| line_crs | input | 1 | Carrier from the medium |

## Verification
The bench builds the block with RST_CYCLES = 8, WAKE_CYCLES = 12 and LOOP_DEPTH = 3, and ties `strap_speed` high. These short windows let the bench count every cycle of the reset, guard and wake sequences and place each edge exactly. They also let it slip a write into the middle of a reset. The eight writable bit positions 14..7 are swept through all 256 combinations. For each combination the bench computes the read value, the link selection, the restart pulse and the data-path gating arithmetically. A separate loopback stream checks the three-cycle delay and the ordering.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  // Bit positions of the mode word; the management side decodes these.
  localparam int unsigned B_SRST  = 15;
  localparam int unsigned B_LOOP  = 14;
  localparam int unsigned B_SPD   = 13;
  localparam int unsigned B_ANE   = 12;
  localparam int unsigned B_PDWN  = 11;
  localparam int unsigned B_ISOL  = 10;
  localparam int unsigned B_ANRS  = 9;
  localparam int unsigned B_DPX   = 8;
  localparam int unsigned B_CTEST = 7;

  localparam int unsigned GUARD_CYCLES = 3;

  typedef struct packed {
    logic loop;
    logic spd;
    logic ane;
    logic pdwn;
    logic isol;
    logic dpx;
    logic ctest;
  } mode_t;

  function automatic mode_t mode_default(input logic strap);
    mode_t m;
    m       = '0;
    m.spd   = strap;
    m.ane   = 1'b1;
    m.dpx   = 1'b1;
    return m;
  endfunction

  function automatic mode_t mode_unpack(input logic [15:0] w);
    mode_t m;
    m.loop  = w[B_LOOP];
    m.spd   = w[B_SPD];
    m.ane   = w[B_ANE];
    m.pdwn  = w[B_PDWN];
    m.isol  = w[B_ISOL];
    m.dpx   = w[B_DPX];
    m.ctest = w[B_CTEST];
    return m;
  endfunction

  function automatic logic [15:0] mode_pack(input mode_t m, input logic busy);
    logic [15:0] w;
    w          = '0;
    w[B_SRST]  = busy;
    w[B_LOOP]  = m.loop;
    w[B_SPD]   = m.spd;
    w[B_ANE]   = m.ane;
    w[B_PDWN]  = m.pdwn;
    w[B_ISOL]  = m.isol;
    w[B_DPX]   = m.dpx;
    w[B_CTEST] = m.ctest;
    return w;
  endfunction

endpackage

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 60000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_speed,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output mode_t       mode,
  output logic        busy,
  output logic        an_restart,
  output logic        st_guard
);

  localparam int unsigned CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
  localparam int unsigned GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);
  localparam logic [GW-1:0] GRD_LOAD = GW'(GUARD_CYCLES);

  mode_t         mode_q, mode_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] grd_q, grd_d;
  logic          rs_q, rs_d;

  always_comb begin
    mode_d = mode_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rs_d   = 1'b0;
    grd_d  = (grd_q != '0) ? grd_q - 1'b1 : grd_q;
    if (busy_q) begin
      mode_d = mode_default(strap_speed);
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        grd_d  = GRD_LOAD;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (wr_en) begin
      if (wdata[B_SRST]) begin
        busy_d = 1'b1;
        cnt_d  = CNT_LOAD;
        mode_d = mode_default(strap_speed);
      end else begin
        mode_d = mode_unpack(wdata);
        rs_d   = wdata[B_ANRS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_default(strap_speed);
      busy_q <= 1'b0;
      cnt_q  <= '0;
      grd_q  <= '0;
      rs_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      grd_q  <= grd_d;
      rs_q   <= rs_d;
    end
  end

  assign mode       = mode_q;
  assign busy       = busy_q;
  assign an_restart = rs_q;
  assign st_guard   = (grd_q != '0);

endmodule

// File: rtl/phy_loop_pipe.sv
module phy_loop_pipe #(
  parameter int unsigned DW    = 4,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [DW-1:0] in_d,
  input  logic          in_en,
  input  logic          in_er,
  output logic [DW-1:0] out_d,
  output logic          out_en,
  output logic          out_er
);

  localparam int unsigned SW = DW + 2;

  logic [DEPTH-1:0][SW-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = flush ? '0 : {in_er, in_en, in_d};
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_comb begin
      stg_d[i] = flush ? '0 : stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign {out_er, out_en, out_d} = stg_q[DEPTH-1];

endmodule

// File: rtl/phy_wake_timer.sv
module phy_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 25000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic ready
);

  localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] W_LOAD = WW'(WAKE_CYCLES);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = hold || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (hold) begin
      cnt_d = W_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W_LOAD;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = (cnt_q == '0) && !hold;

endmodule

// File: rtl/phy_mode_ctl.sv
module phy_mode_ctl
  import phy_ctl_pkg::*;
#(
  parameter int unsigned DW          = 4,
  parameter int unsigned AW          = 5,
  parameter int unsigned RST_CYCLES  = 60000,
  parameter int unsigned WAKE_CYCLES = 25000000,
  parameter int unsigned LOOP_DEPTH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_speed,
  input  logic [AW-1:0] mg_addr,
  input  logic [15:0]   mg_wdata,
  input  logic          mg_we,
  output logic [15:0]   mg_rdata,
  input  logic          an_res_100,
  input  logic          an_res_fdx,
  output logic          link_100,
  output logic          link_fdx,
  output logic          an_restart,
  output logic          st_guard,
  output logic          port_ready,
  output logic          mii_oe,
  input  logic [DW-1:0] tx_d,
  input  logic          tx_en,
  input  logic          tx_er,
  output logic [DW-1:0] rx_d,
  output logic          rx_dv,
  output logic          rx_er,
  output logic          col,
  output logic          crs,
  output logic [DW-1:0] line_tx_d,
  output logic          line_tx_en,
  output logic          line_tx_er,
  input  logic [DW-1:0] line_rx_d,
  input  logic          line_rx_dv,
  input  logic          line_rx_er,
  input  logic          line_col,
  input  logic          line_crs
);

  mode_t         mode;
  logic          ctl_busy;
  logic          ctl_sel;
  logic          data_on;
  logic          loop_on;
  logic [DW-1:0] lp_in_d, lp_out_d;
  logic          lp_in_en, lp_in_er, lp_out_en, lp_out_er;

  assign ctl_sel = (mg_addr == '0);

  phy_ctl_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_speed(strap_speed),
    .wr_en      (mg_we && ctl_sel),
    .wdata      (mg_wdata),
    .mode       (mode),
    .busy       (ctl_busy),
    .an_restart (an_restart),
    .st_guard   (st_guard)
  );

  assign mg_rdata = ctl_sel ? mode_pack(mode, ctl_busy) : 16'h0000;

  assign link_100 = mode.ane ? an_res_100 : mode.spd;
  assign link_fdx = mode.ane ? an_res_fdx : mode.dpx;

  assign data_on = !mode.pdwn && !mode.isol && !ctl_busy;
  assign loop_on = mode.loop && data_on;
  assign mii_oe  = !mode.isol;

  assign lp_in_d  = loop_on ? tx_d  : '0;
  assign lp_in_en = loop_on && tx_en;
  assign lp_in_er = loop_on && tx_er;

  phy_loop_pipe #(.DW(DW), .DEPTH(LOOP_DEPTH)) u_loop (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctl_busy),
    .in_d  (lp_in_d),
    .in_en (lp_in_en),
    .in_er (lp_in_er),
    .out_d (lp_out_d),
    .out_en(lp_out_en),
    .out_er(lp_out_er)
  );

  phy_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (mode.pdwn || mode.isol || ctl_busy),
    .ready(port_ready)
  );

  always_comb begin
    line_tx_d  = '0;
    line_tx_en = 1'b0;
    line_tx_er = 1'b0;
    rx_d       = '0;
    rx_dv      = 1'b0;
    rx_er      = 1'b0;
    col        = 1'b0;
    crs        = 1'b0;
    if (data_on) begin
      if (mode.loop) begin
        rx_d  = lp_out_d;
        rx_dv = lp_out_en;
        rx_er = lp_out_er;
        crs   = lp_out_en;
        col   = mode.ctest && tx_en;
      end else begin
        line_tx_d  = tx_d;
        line_tx_en = tx_en;
        line_tx_er = tx_er;
        rx_d       = line_rx_d;
        rx_dv      = line_rx_dv;
        rx_er      = line_rx_er;
        crs        = line_crs;
        col        = mode.ctest ? tx_en : line_col;
      end
    end
  end

endmodule

// File: rtl/phy_mode_ctl_chk.sv
module phy_mode_ctl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mg_we,
  input logic [AW-1:0] mg_addr,
  input logic          wr_srst,
  input logic          busy,
  input logic          st_guard,
  input logic          an_restart,
  input logic          m_ane,
  input logic          m_spd,
  input logic          m_dpx,
  input logic          m_loop,
  input logic          m_isol,
  input logic          m_pdwn,
  input logic          link_100,
  input logic          link_fdx,
  input logic          an_res_100,
  input logic          an_res_fdx,
  input logic          port_ready,
  input logic          mii_oe,
  input logic          line_tx_en,
  input logic          rx_dv,
  input logic          col
);

  // R4
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_we && mg_addr == '0 && wr_srst && !busy) |=> busy);

  // R5
  guard_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> st_guard);

  // R7
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);

  // R6
  manual_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ane |-> (link_100 == m_spd && link_fdx == m_dpx));

  // R6
  an_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_ane |-> (link_100 == an_res_100 && link_fdx == an_res_fdx));

  // R9
  isolate_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_isol |-> (!mii_oe && !port_ready && !line_tx_en));

  // R10
  pdwn_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_pdwn |-> (!port_ready && !line_tx_en && !rx_dv && !col));

  // R8
  loop_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_loop |-> !line_tx_en);

endmodule

bind phy_mode_ctl phy_mode_ctl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mg_we      (mg_we),
  .mg_addr    (mg_addr),
  .wr_srst    (mg_wdata[15]),
  .busy       (ctl_busy),
  .st_guard   (st_guard),
  .an_restart (an_restart),
  .m_ane      (mode.ane),
  .m_spd      (mode.spd),
  .m_dpx      (mode.dpx),
  .m_loop     (mode.loop),
  .m_isol     (mode.isol),
  .m_pdwn     (mode.pdwn),
  .link_100   (link_100),
  .link_fdx   (link_fdx),
  .an_res_100 (an_res_100),
  .an_res_fdx (an_res_fdx),
  .port_ready (port_ready),
  .mii_oe     (mii_oe),
  .line_tx_en (line_tx_en),
  .rx_dv      (rx_dv),
  .col        (col)
);

// File: tb/sim_phy_mode_ctl.sv
module sim_phy_mode_ctl;

  localparam int DW = 4;
  localparam int AW = 5;
  localparam int RC = 8;
  localparam int WC = 12;
  localparam int LD = 3;

  logic          clk;
  logic          rst_n;
  logic          strap_speed;
  logic [AW-1:0] mg_addr;
  logic [15:0]   mg_wdata;
  logic          mg_we;
  logic [15:0]   mg_rdata;
  logic          an_res_100, an_res_fdx;
  logic          link_100, link_fdx, an_restart, st_guard, port_ready, mii_oe;
  logic [DW-1:0] tx_d, rx_d, line_tx_d, line_rx_d;
  logic          tx_en, tx_er, rx_dv, rx_er, col, crs;
  logic          line_tx_en, line_tx_er, line_rx_dv, line_rx_er, line_col, line_crs;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  phy_mode_ctl #(.DW(DW), .AW(AW), .RST_CYCLES(RC), .WAKE_CYCLES(WC), .LOOP_DEPTH(LD)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_speed(strap_speed),
    .mg_addr(mg_addr), .mg_wdata(mg_wdata), .mg_we(mg_we), .mg_rdata(mg_rdata),
    .an_res_100(an_res_100), .an_res_fdx(an_res_fdx),
    .link_100(link_100), .link_fdx(link_fdx), .an_restart(an_restart),
    .st_guard(st_guard), .port_ready(port_ready), .mii_oe(mii_oe),
    .tx_d(tx_d), .tx_en(tx_en), .tx_er(tx_er),
    .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er), .col(col), .crs(crs),
    .line_tx_d(line_tx_d), .line_tx_en(line_tx_en), .line_tx_er(line_tx_er),
    .line_rx_d(line_rx_d), .line_rx_dv(line_rx_dv), .line_rx_er(line_rx_er),
    .line_col(line_col), .line_crs(line_crs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // Write one word; returns 1 time unit after the capturing edge.
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    mg_addr  = a;
    mg_wdata = d;
    mg_we    = 1'b1;
    @(posedge clk);
    #1;
    mg_we    = 1'b0;
    mg_addr  = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] w;
    logic lp, sp, an, pd, is, dx, ct, on;
    logic [DW-1:0] hist_d [0:19];
    logic hist_en [0:19];
    logic hist_er [0:19];
    strap_speed = 1'b1;
    mg_addr = '0; mg_wdata = '0; mg_we = 1'b0;
    an_res_100 = 1'b0; an_res_fdx = 1'b0;
    tx_d = '0; tx_en = 1'b0; tx_er = 1'b0;
    line_rx_d = '0; line_rx_dv = 1'b0; line_rx_er = 1'b0; line_col = 1'b0; line_crs = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #5;

    // R1 reset state
    chk("R1 rdata", mg_rdata, 16'h3100);
    chk("R1 port_ready", {15'b0, port_ready}, 16'h0);
    chk("R1 st_guard", {15'b0, st_guard}, 16'h0);
    chk("R1 an_restart", {15'b0, an_restart}, 16'h0);

    // R2/R6/R7/R9/R10/R12 sweep over bits 14..7
    for (int i = 0; i < 256; i++) begin
      w = 16'(i) << 7;
      an_res_100 = i[1] ^ i[3];
      an_res_fdx = i[0];
      wr('0, w);
      #3;
      chk("R7 pulse", {15'b0, an_restart}, {15'b0, w[9]});
      chk("R2 readback", mg_rdata, w & 16'h7D80);
      lp = w[14]; sp = w[13]; an = w[12]; pd = w[11]; is = w[10]; dx = w[8]; ct = w[7];
      chk("R6 speed", {15'b0, link_100}, {15'b0, an ? an_res_100 : sp});
      chk("R6 duplex", {15'b0, link_fdx}, {15'b0, an ? an_res_fdx : dx});
      @(posedge clk); #4;
      chk("R7 single", {15'b0, an_restart}, 16'h0);
      tx_d = 4'(i) ^ 4'h5; tx_en = 1'b1; tx_er = i[2];
      line_rx_d = ~4'(i); line_rx_dv = 1'b1; line_rx_er = i[4]; line_col = i[5]; line_crs = 1'b1;
      #1;
      on = !pd && !is;
      chk("R9 mii_oe", {15'b0, mii_oe}, {15'b0, !is});
      if (pd || is) chk("R11 held low", {15'b0, port_ready}, 16'h0);
      chk("R12 line_tx", {9'b0, line_tx_er, line_tx_en, 1'b0, line_tx_d},
          (on && !lp) ? {9'b0, tx_er, tx_en, 1'b0, tx_d} : 16'h0);
      chk("R12 col", {15'b0, col}, {15'b0, on && (ct ? tx_en : (!lp && line_col))});
      if (!lp || !on)
        chk("R10 rx", {8'b0, crs, rx_er, rx_dv, 1'b0, rx_d},
            on ? {8'b0, line_crs, line_rx_er, line_rx_dv, 1'b0, line_rx_d} : 16'h0);
    end
    tx_en = 1'b0; tx_er = 1'b0; tx_d = '0;

    // R10 power-down keeps contents
    wr('0, 16'h0980);
    #4 chk("R10 kept", mg_rdata, 16'h0980);

    // R3 other addresses
    wr(5'd1, 16'hFFFF);
    #4 chk("R3 unchanged", mg_rdata, 16'h0980);
    mg_addr = 5'd1; #1;
    chk("R3 reads zero", mg_rdata, 16'h0);
    mg_addr = 5'd31; #1;
    chk("R3 reads zero top", mg_rdata, 16'h0);
    mg_addr = '0;

    // R11 wake timing
    repeat (3) @(posedge clk);
    #4 chk("R11 low in pdwn", {15'b0, port_ready}, 16'h0);
    wr('0, 16'h0000);
    for (int k = 1; k <= WC + 2; k++) begin
      @(posedge clk); #5;
      chk("R11 wake", {15'b0, port_ready}, {15'b0, k >= WC});
    end

    // R8 loopback stream
    wr('0, 16'h4000);
    repeat (LD + 2) @(posedge clk);
    for (int j = 0; j < 20; j++) begin
      @(posedge clk); #1;
      hist_d[j]  = 4'(j * 3 + 1);
      hist_en[j] = (j % 7) != 5;
      hist_er[j] = (j % 4) == 2;
      tx_d = hist_d[j]; tx_en = hist_en[j]; tx_er = hist_er[j];
      #4;
      if (j >= LD)
        chk("R8 loop data", {8'b0, crs, rx_er, rx_dv, 1'b0, rx_d},
            {8'b0, hist_en[j-LD], hist_er[j-LD], hist_en[j-LD], 1'b0, hist_d[j-LD]});
      else
        chk("R8 loop prefill", {8'b0, crs, rx_er, rx_dv, 1'b0, rx_d}, 16'h0);
      chk("R8 line idle", {14'b0, col, line_tx_en}, 16'h0);
    end
    tx_en = 1'b0; tx_er = 1'b0; tx_d = '0;

    // R4/R5 soft reset with a write attempt inside the window
    wr('0, 16'h8000);
    #4;
    chk("R4 bit15 set", mg_rdata, 16'hB100);
    for (int k = 1; k <= RC + 4; k++) begin
      @(posedge clk); #5;
      if (k == 3) mg_we = 1'b0;
      chk("R4 busy window", mg_rdata, (k < RC) ? 16'hB100 : 16'h3100);
      chk("R5 guard", {15'b0, st_guard}, {15'b0, (k >= RC) && (k < RC + 3)});
      chk("R11 reset low", {15'b0, port_ready}, 16'h0);
      if (k == 2) begin
        #1;
        mg_addr = '0; mg_wdata = 16'h0000; mg_we = 1'b1;
      end
    end
    mg_we = 1'b0;
    chk("R4 write ignored", mg_rdata, 16'h3100);

    summary();
  end

endmodule